// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block lets an external two-wire bus master read and write a bank of 8-bit configuration registers. It only ever acts as a slave. Every flop runs on a fast system clock, which must be at least four times faster than the serial clock. The serial clock and data lines are sampled as plain inputs through synchronizers. The block pulls the data line low through an open-drain enable (`sda_oe` = 1 means pull low) and never drives it high.

The 7-bit device address comes from a strap pin, which is sampled while reset is asserted. Bits 7:1 of a mode register hold the active address, so a write to that field changes the address that later transactions must match. Bit 0 of the same register turns on burst writing. In burst writing, one transaction can carry several data bytes, and each byte goes to the next register address. A host-side port lets surrounding logic, or a testbench, read and write the bank directly.

The state machine has these states: `ST_IDLE`, `ST_DEV` (receiving the address byte), `ST_DEV_ACK`, `ST_REG` (receiving the register pointer), `ST_REG_ACK`, `ST_WDATA` (receiving write data), `ST_WDATA_ACK`, `ST_RDATA` (sending read data) and `ST_RDATA_ACK` (sampling the master's acknowledge).

Transitions:
- A stop takes any state to `ST_IDLE`. A start takes any state to `ST_DEV`.
- `ST_DEV` goes to `ST_DEV_ACK` on an address match and to `ST_IDLE` on a miss.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read and to `ST_REG` for a write.
- `ST_REG` goes to `ST_REG_ACK`, and `ST_REG_ACK` goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`.
- `ST_WDATA_ACK` goes back to `ST_WDATA` when burst writing is on, and to `ST_IDLE` otherwise.
- `ST_RDATA` goes to `ST_RDATA_ACK`.
- `ST_RDATA_ACK` goes to `ST_RDATA` when the master acknowledges, and to `ST_IDLE` on a not-acknowledge.

All transitions out of byte and acknowledge states happen on a synchronized falling edge of SCL.

Top module: `i2c_cfg_slave`

## Requirements
- R1: During reset the mode register (internal address 0xF0) loads {7'b1010101, 1'b0} when `addr_strap` is 0 and {7'b0110011, 1'b0} when it is 1. The slave then answers to that 7-bit address.
- R2: A start (SDA falling while SCL is high) restarts address reception from any state. A stop (SDA rising while SCL is high) returns the slave to idle with SDA released.
- R3: On a matching address byte, the slave holds SDA low for the whole high phase of the ninth clock. On a mismatch it never pulls SDA low, and it writes nothing until the next start.
- R4: A write transaction stores the data byte in the register selected by the register-address byte. The slave acknowledges all three bytes. The address byte is sent MSB first, with the R/W bit last (0 = write).
- R5: With mode bit 0 set, every further data byte in the same transaction is acknowledged and written to the previous register address plus one, wrapping from 0xFF to 0x00.
- R6: With mode bit 0 clear, a second data byte in one transaction is not acknowledged and is not written.
- R7: A read sends the register address in write direction, then a repeated start and the address byte with R/W = 1. After acknowledging, the slave shifts out the selected register MSB first. A master not-acknowledge ends the read.
- R8: If the master acknowledges a read byte, the slave then sends the register at the next address.
- R9: Writing bits 7:1 of the mode register replaces the device address. The previous address is no longer acknowledged, and the new one is.
- R10: The slave changes SDA only after a detected falling edge of SCL, so SDA never changes while SCL is high during well-formed traffic.
- R11: `host_rdata` shows the register at `host_addr` combinationally, and a `host_we` pulse writes `host_wdata` into it.
- R12: After reset `sda_oe` is 0 and every register other than the mode register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SCL rate |
| rst_n | input | 1 | Active-low reset, sampled on clk |
| addr_strap | input | 1 | Selects the default device address during reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| host_we | input | 1 | Host write strobe into the register bank |
| host_addr | input | REG_AW | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register contents at host_addr |

## Verification
The hardest case to reach is the pointer wrap in burst mode. It needs the mode bit set over the bus, followed by one transaction that starts at 0xFE and runs three data bytes, so the write crosses 0xFF into 0x00. A second hard case is reprogramming the address over the bus. The mode register must be written through the old address, and the following transactions must then show the old address being refused and the new one accepted. Between these directed steps, randomly chosen register addresses and data are written and read back through repeated-start reads. The readback is compared with a bench model.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR7_W = 7;

    // Default device addresses selected by the strap pin during reset
    localparam logic [ADDR7_W-1:0] STRAP_ADDR_LO = 7'b1010101;
    localparam logic [ADDR7_W-1:0] STRAP_ADDR_HI = 7'b0110011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Both lines idle high, so the chain resets to 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // SDA edges count as start or stop only while SCL stays high
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_cfg_regbank.sv
module i2c_cfg_regbank
    import i2c_cfg_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic [ADDR_W-1:0] bus_raddr,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic [ADDR7_W-1:0] dev_addr,
    output logic              burst_en
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] regs [DEPTH];
    logic [BYTE_W-1:0] mode_init;

    assign mode_init = {(strap ? STRAP_ADDR_HI : STRAP_ADDR_LO), 1'b0};

    // Serial-bus write takes priority over a host write in the same cycle
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                regs[i] <= (ADDR_W'(i) == MODE_ADDR) ? mode_init : '0;
            end else if (bus_we && bus_waddr == ADDR_W'(i)) begin
                regs[i] <= bus_wdata;
            end else if (host_we && host_addr == ADDR_W'(i)) begin
                regs[i] <= host_wdata;
            end
        end
    end

    assign bus_rdata  = regs[bus_raddr];
    assign host_rdata = regs[host_addr];
    assign dev_addr   = regs[MODE_ADDR][BYTE_W-1:1];
    assign burst_en   = regs[MODE_ADDR][0];

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import i2c_cfg_pkg::*;
#(
    parameter int                REG_AW      = 8,
    parameter logic [REG_AW-1:0] MODE_ADDR   = 8'hF0,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strap,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              host_we,
    input  logic [REG_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    slv_state_t         state, nxt_state;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  rx_sh;
    logic [BYTE_W-1:0]  tx_sh;
    logic [REG_AW-1:0]  reg_ptr;
    logic               rw_bit;
    logic               mack_n;
    logic               bus_we;
    logic [REG_AW-1:0]  wr_addr;
    logic [BYTE_W-1:0]  wr_data;
    logic [REG_AW-1:0]  rd_addr;
    logic [BYTE_W-1:0]  rd_data;
    logic [ADDR7_W-1:0] dev_addr;
    logic               burst_en;
    logic               byte_done;
    logic               addr_hit;
    logic               counting;

    // While the master acknowledge is pending, look ahead to the next register
    assign rd_addr = (state == ST_RDATA_ACK) ? reg_ptr + REG_AW'(1) : reg_ptr;

    i2c_cfg_regbank #(.ADDR_W(REG_AW), .MODE_ADDR(MODE_ADDR)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap      (addr_strap),
        .bus_we     (bus_we),
        .bus_waddr  (wr_addr),
        .bus_wdata  (wr_data),
        .bus_raddr  (rd_addr),
        .bus_rdata  (rd_data),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .dev_addr   (dev_addr),
        .burst_en   (burst_en)
    );

    assign byte_done = (bit_cnt == LAST_BIT);
    assign addr_hit  = (rx_sh[BYTE_W-1:1] == dev_addr);
    assign counting  = (state == ST_DEV) || (state == ST_REG) ||
                       (state == ST_WDATA) || (state == ST_RDATA);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // Next-state logic
    always_comb begin
        nxt_state = state;
        if (stop_det) begin
            nxt_state = ST_IDLE;
        end else if (start_det) begin
            nxt_state = ST_DEV;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:      nxt_state = ST_IDLE;
                ST_DEV:       if (byte_done) nxt_state = addr_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   nxt_state = rw_bit ? ST_RDATA : ST_REG;
                ST_REG:       if (byte_done) nxt_state = ST_REG_ACK;
                ST_REG_ACK:   nxt_state = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt_state = ST_WDATA_ACK;
                ST_WDATA_ACK: nxt_state = burst_en ? ST_WDATA : ST_IDLE;
                ST_RDATA:     if (byte_done) nxt_state = ST_RDATA_ACK;
                ST_RDATA_ACK: nxt_state = mack_n ? ST_IDLE : ST_RDATA;
                default:      nxt_state = ST_IDLE;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            reg_ptr <= '0;
            rw_bit  <= 1'b0;
            mack_n  <= 1'b1;
            bus_we  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            sda_oe  <= 1'b0;
        end else begin
            bus_we <= 1'b0;

            if (nxt_state != state)
                bit_cnt <= '0;
            else if (scl_rise && counting)
                bit_cnt <= bit_cnt + CNT_W'(1);

            if (scl_rise && (state == ST_DEV || state == ST_REG || state == ST_WDATA))
                rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};

            if (scl_rise && state == ST_RDATA_ACK)
                mack_n <= sda_s;

            if (stop_det || start_det) begin
                sda_oe <= 1'b0;
            end else if (scl_fall) begin
                unique case (state)
                    ST_DEV: begin
                        if (byte_done && addr_hit) begin
                            sda_oe <= 1'b1;
                            rw_bit <= rx_sh[0];
                        end
                    end
                    ST_REG: begin
                        if (byte_done) begin
                            reg_ptr <= rx_sh[REG_AW-1:0];
                            sda_oe  <= 1'b1;
                        end
                    end
                    ST_WDATA: begin
                        if (byte_done) begin
                            bus_we  <= 1'b1;
                            wr_addr <= reg_ptr;
                            wr_data <= rx_sh;
                            sda_oe  <= 1'b1;
                            if (burst_en) reg_ptr <= reg_ptr + REG_AW'(1);
                        end
                    end
                    ST_DEV_ACK: begin
                        if (rw_bit) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_RDATA: begin
                        if (byte_done) begin
                            sda_oe <= 1'b0;
                        end else begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_sh[BYTE_W-2];
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (!mack_n) begin
                            reg_ptr <= rd_addr;
                            tx_sh   <= rd_data;
                            sda_oe  <= ~rd_data[BYTE_W-1];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_REG_ACK, ST_WDATA_ACK: sda_oe <= 1'b0;
                    ST_IDLE:                  sda_oe <= 1'b0;
                    default:                  sda_oe <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk
    import i2c_cfg_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input slv_state_t state,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       scl_fall,
    input logic       start_det,
    input logic       stop_det,
    input logic       bus_we
);

    // R10: SDA drive changes only right after an SCL fall, start or stop
    assert_oe_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R10: while SCL is steadily high, the drive is stable unless a bus condition occurred
    assert_oe_stable_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R2: a stop returns to idle with SDA released
    assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R2: a start restarts address reception
    assert_start_dev_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det) |=> (state == ST_DEV));

    // R3: the line is held low throughout every slave acknowledge slot
    assert_ack_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEV_ACK || state == ST_REG_ACK || state == ST_WDATA_ACK) |-> sda_oe);

    // R3: an idle or ignoring slave never pulls SDA
    assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    // R4: register writes happen only on an acknowledged data byte
    assert_write_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (state == ST_WDATA_ACK));

endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .sda_oe    (sda_oe),
    .scl_s     (scl_s),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .bus_we    (bus_we)
);

// File: tb/test_i2c_cfg_slave.sv
module test_i2c_cfg_slave;

    localparam int H = 8;   // SCL half period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_strap = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    wire        sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_cfg_slave i_i2c_cfg_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_strap (addr_strap),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    int   errors = 0;
    int   checks = 0;
    int   r10_viol = 0;
    logic done = 1'b0;
    logic [7:0] model [256];

    // R10 monitor: drive changes while SCL has been high for two samples
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    always @(posedge clk) begin
        if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) r10_viol++;
        prev_oe  = sda_oe;
        prev_scl = scl_m;
    end

    function automatic logic [6:0] strap_addr(input logic s);
        return s ? 7'b0110011 : 7'b1010101;
    endfunction

    function automatic logic [7:0] mode_val(input logic [6:0] a, input logic burst);
        return {a, burst};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic s);
        rst_n = 1'b0; addr_strap = s; scl_m = 1'b1; sda_m = 1'b1;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        model[8'hF0] = mode_val(strap_addr(s), 1'b0);
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d);
        host_addr = a;
        tick(1);
        d = host_rdata;
    endtask

    task automatic b_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic b_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic b_put(input logic [7:0] b, output logic ack);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(2);
        a1 = ~sda_line; tick(H - 2);
        a2 = ~sda_line;
        scl_m = 1'b0;
        ack = a1 & a2;
    endtask

    task automatic b_get(output logic [7:0] d, input logic nack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl_m = 1'b1; tick(H / 2);
            d[i] = sda_line; tick(H / 2);
            scl_m = 1'b0;
        end
        sda_m = nack; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic wr1(input logic [6:0] dv, input logic [7:0] ra, input logic [7:0] wd,
                       output logic ok);
        logic a0, a1, a2;
        b_start();
        b_put({dv, 1'b0}, a0);
        b_put(ra, a1);
        b_put(wd, a2);
        b_stop();
        ok = a0 & a1 & a2;
        if (ok) model[ra] = wd;
    endtask

    task automatic rd1(input logic [6:0] dv, input logic [7:0] ra, output logic [7:0] d,
                       output logic ok);
        logic a0, a1, a2;
        b_start();
        b_put({dv, 1'b0}, a0);
        b_put(ra, a1);
        b_start();
        b_put({dv, 1'b1}, a2);
        b_get(d, 1'b1);
        b_stop();
        ok = a0 & a1 & a2;
    endtask

    initial begin
        logic       ok, a0, a1, a2, a3, a4;
        logic [7:0] d, d2;
        logic [6:0] dev;
        logic [7:0] ra, rb, wd;
        int         seed;

        seed = $urandom(32'h5EED_1234);
        do_reset(1'b0);
        dev = strap_addr(1'b0);

        // R12, R1: reset state
        chk("R12 sda_oe after reset", sda_oe, 1'b0);
        host_read(8'hF0, d);
        chk("R1 mode register strap low", d, mode_val(7'h55, 1'b0));
        host_read(8'h10, d);
        chk("R12 plain register after reset", d, 8'h00);

        // R4: single write
        wr1(dev, 8'h10, 8'h5A, ok);
        chk("R4 write acknowledged", ok, 1'b1);
        host_read(8'h10, d);
        chk("R4 register written", d, 8'h5A);

        // R3: mismatching address is ignored
        b_start();
        b_put({7'h33, 1'b0}, a0);
        b_put(8'h20, a1);
        b_put(8'h99, a2);
        b_stop();
        chk("R3 no ack on mismatch", {a0, a1, a2}, 3'b000);
        host_read(8'h20, d);
        chk("R3 mismatch writes nothing", d, 8'h00);

        // R7, R2: random read through repeated start
        rd1(dev, 8'h10, d, ok);
        chk("R7 read acks", ok, 1'b1);
        chk("R7 read data", d, 8'h5A);
        chk("R2 SDA released after stop", sda_oe, 1'b0);

        // R8: master ACK continues to next register
        wr1(dev, 8'h11, 8'hC3, ok);
        b_start();
        b_put({dev, 1'b0}, a0);
        b_put(8'h10, a1);
        b_start();
        b_put({dev, 1'b1}, a2);
        b_get(d, 1'b0);
        b_get(d2, 1'b1);
        b_stop();
        chk("R8 first byte", d, 8'h5A);
        chk("R8 second byte from next address", d2, 8'hC3);

        // R6: burst off, second data byte refused
        b_start();
        b_put({dev, 1'b0}, a0);
        b_put(8'h30, a1);
        b_put(8'h11, a2);
        b_put(8'h22, a3);
        b_stop();
        chk("R6 first byte acked", {a0, a1, a2}, 3'b111);
        chk("R6 second byte not acked", a3, 1'b0);
        host_read(8'h31, d);
        chk("R6 second byte not written", d, 8'h00);
        model[8'h30] = 8'h11;

        // R5: enable burst over the bus, then wrap FE -> FF -> 00
        wr1(dev, 8'hF0, mode_val(dev, 1'b1), ok);
        chk("R5 mode write acked", ok, 1'b1);
        b_start();
        b_put({dev, 1'b0}, a0);
        b_put(8'hFE, a1);
        b_put(8'h01, a2);
        b_put(8'h02, a3);
        b_put(8'h03, a4);
        b_stop();
        chk("R5 burst acks", {a0, a1, a2, a3, a4}, 5'b11111);
        model[8'hFE] = 8'h01; model[8'hFF] = 8'h02; model[8'h00] = 8'h03;
        host_read(8'hFF, d);
        chk("R5 second burst byte", d, 8'h02);
        host_read(8'h00, d);
        chk("R5 wrapped to 00", d, 8'h03);

        // R2: start in the middle of a transaction restarts address reception
        b_start();
        b_put({dev, 1'b0}, a0);
        b_put(8'h40, a1);
        b_start();
        b_put({dev, 1'b0}, a2);
        b_put(8'h41, a3);
        b_put(8'h77, a4);
        b_stop();
        model[8'h41] = 8'h77;
        chk("R2 restart acks", {a2, a3, a4}, 3'b111);
        host_read(8'h41, d);
        chk("R2 write after restart", d, 8'h77);
        host_read(8'h40, d);
        chk("R2 aborted pointer untouched", d, 8'h00);

        // Random writes and reads against the model (R4, R7)
        for (int it = 0; it < 30; it++) begin
            ra = 8'($urandom_range(0, 8'hEF));
            wd = 8'($urandom);
            wr1(dev, ra, wd, ok);
            chk("R4 random write ack", ok, 1'b1);
            rb = 8'($urandom_range(0, 8'hEF));
            if (it % 2 == 0) rb = ra;
            rd1(dev, rb, d, ok);
            chk("R7 random readback", d, model[rb]);
        end

        // R11: host port
        host_addr = 8'h50; host_wdata = 8'hE7; host_we = 1'b1;
        tick(1);
        host_we = 1'b0;
        model[8'h50] = 8'hE7;
        host_read(8'h50, d);
        chk("R11 host write/read", d, 8'hE7);
        rd1(dev, 8'h50, d, ok);
        chk("R11 host write visible on bus", d, 8'hE7);

        // R9: reprogram the device address
        wr1(dev, 8'hF0, mode_val(7'h12, 1'b0), ok);
        chk("R9 address change acked", ok, 1'b1);
        wr1(7'h55, 8'h60, 8'h9C, ok);
        chk("R9 old address refused", ok, 1'b0);
        host_read(8'h60, d);
        chk("R9 old address writes nothing", d, 8'h00);
        wr1(7'h12, 8'h60, 8'h9C, ok);
        chk("R9 new address accepted", ok, 1'b1);
        host_read(8'h60, d);
        chk("R9 new address writes", d, 8'h9C);

        chk("R10 no SDA change while SCL high", r10_viol, 0);

        // R1, R12: strap high
        do_reset(1'b1);
        host_read(8'hF0, d);
        chk("R1 mode register strap high", d, mode_val(7'h33, 1'b0));
        host_read(8'h10, d);
        chk("R12 register cleared by reset", d, 8'h00);
        wr1(7'h33, 8'h05, 8'h4D, ok);
        chk("R1 strap-high address acked", ok, 1'b1);
        wr1(7'h55, 8'h06, 8'h4E, ok);
        chk("R1 strap-low address refused", ok, 1'b0);
        host_read(8'h05, d);
        chk("R1 write via strap-high address", d, 8'h4D);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule